// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block produces a periodic interrupt request for a processor interrupt controller. A reference divider makes one tick every four clock cycles. An optional prescale stage of 512 sits after it, and the ticks clock an 8-bit down-counter. When the counter expires, it reloads from the programmed modulus and marks a request pending. The pending request is presented at a programmable level from 1 to 7. During the acknowledge cycle the block returns a programmable 8-bit vector number.

Software programs the block through two registers. The timing register (address 0) holds the modulus in bits [7:0] and the prescale select in bit 8. The control register (address 1) holds the vector in bits [7:0] and the request level in bits [10:8]. The block merges its own request with an external request level, using the higher of the two. It favours itself when the two levels are equal, and it flags whether the merged level is above the current priority mask. A low-power-stop input is present but has no effect, so the timer keeps running through stop. The only way to halt it is to load a modulus of zero.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset the timing register (address 0) reads 0x0000, the control register (address 1) reads 0x000F (vector 0x0F, level 0), and no request is presented.
- R2: With prescale bit 8 clear and modulus M written while the timer is stopped, the timer request appears exactly 4·M clock cycles after the write edge.
- R3: With prescale bit 8 set, the interval is 4·512·M clock cycles.
- R4: The counter reloads itself on expiry, so requests that are acknowledged in time recur every 4·M·prescale cycles without further writes.
- R5: A level of 0 in control bits [10:8] suppresses the timer request, while the counter keeps running and reloading; when a nonzero level is written later, the next request keeps the original period phase. Writing level 0 drops a pending request.
- R6: Writing modulus 0 freezes the counter and clears a pending request; no request appears while the modulus is 0.
- R7: The low-power-stop input has no effect on counting or requests.
- R8: A modulus written while the timer runs takes effect at the next reload; the expiry already in progress keeps the old modulus.
- R9: When the timer level equals a nonzero external level, the timer is the presented source (req_is_timer = 1).
- R10: req_level is the larger of the pending timer level and ext_level, and req_is_timer is 0 when the external level is higher.
- R11: req_take is 1 exactly when req_level is greater than ipl_mask.
- R12: An acknowledge whose level equals the pending timer level raises iack_hit, drives the control vector on iack_vector in the same cycle, and clears the pending request at the next edge.
- R13: An acknowledge at any other level, or with no timer request pending, leaves iack_hit at 0 and iack_vector at 0 and keeps the request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the reference clock for the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 timing, 1 control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| lp_stop | input | 1 | Low-power-stop indication (ignored) |
| ext_level | input | 3 | Level of the competing external request, 0 = none |
| ipl_mask | input | 3 | Current interrupt priority mask |
| req_level | output | 3 | Merged request level presented to the core |
| req_is_timer | output | 1 | Presented request belongs to the timer |
| req_take | output | 1 | Presented level exceeds the mask |
| iack | input | 1 | Interrupt acknowledge cycle |
| iack_level | input | 3 | Level being acknowledged |
| iack_hit | output | 1 | Timer answers this acknowledge |
| iack_vector | output | 8 | Vector number when iack_hit, else 0 |

## Verification
The hardest case to reach is the one where the counter must keep running while nothing can be seen at the ports. This happens when the level is 0 and expiries are suppressed. The stimulus therefore starts a fixed modulus at level 0 and lets two expiries pass silently. It then writes a nonzero level partway through the third period and requires the request at the exact cycle that continuous counting predicts. The equal-level tie and the wrong-level acknowledge need a request that stays pending, so the bench stops acknowledging automatically and holds the request while it sweeps the external level, the mask and the acknowledge level.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int LVL_W = 3;
   typedef logic [LVL_W-1:0] lvl_t;

   typedef enum logic {
      REG_TIMING = 1'b0,
      REG_CTRL   = 1'b1
   } reg_sel_e;

   function automatic lvl_t lvl_max(lvl_t a, lvl_t b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int VEC_W   = 8,
   parameter int DATA_W  = 16,
   parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [CNT_W-1:0]  mod_q,
   output logic              pre_q,
   output lvl_t              lvl_q,
   output logic [VEC_W-1:0]  vec_q,
   output logic              tm_wr,
   output logic [CNT_W-1:0]  wr_mod,
   output logic              lvl_kill
);
   localparam int PRE_BIT = CNT_W;
   localparam int LVL_LSB = VEC_W;

   logic ctl_wr;
   lvl_t wr_lvl;

   assign tm_wr    = reg_wr && (reg_sel_e'(reg_addr) == REG_TIMING);
   assign ctl_wr   = reg_wr && (reg_sel_e'(reg_addr) == REG_CTRL);
   assign wr_mod   = reg_wdata[CNT_W-1:0];
   assign wr_lvl   = reg_wdata[LVL_LSB +: LVL_W];
   assign lvl_kill = ctl_wr && (wr_lvl == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q <= '0;
         pre_q <= 1'b0;
      end else if (tm_wr) begin
         mod_q <= wr_mod;
         pre_q <= reg_wdata[PRE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         vec_q <= VEC_RST;
      end else if (ctl_wr) begin
         lvl_q <= wr_lvl;
         vec_q <= reg_wdata[VEC_W-1:0];
      end
   end

   always_comb begin
      if (reg_sel_e'(reg_addr) == REG_TIMING)
         reg_rdata = DATA_W'({pre_q, mod_q});
      else
         reg_rdata = DATA_W'({lvl_q, vec_q});
   end
endmodule

// File: rtl/pit_tick_gen.sv
module pit_tick_gen #(
   parameter int REF_DIV = 4,
   parameter int PRE_DIV = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pre_sel,
   output logic step
);
   localparam int REF_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
   localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   logic ref_tick;

   generate
      if (REF_DIV == 1) begin : g_ref_bypass
         assign ref_tick = run;
      end else begin : g_ref_div
         logic [REF_W-1:0] ref_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            ref_q <= '0;
            else if (!run)                         ref_q <= '0;
            else if (ref_q == REF_W'(REF_DIV - 1)) ref_q <= '0;
            else                                   ref_q <= ref_q + 1'b1;
         end
         assign ref_tick = run && (ref_q == REF_W'(REF_DIV - 1));
      end

      if (PRE_DIV == 1) begin : g_pre_bypass
         assign step = ref_tick;
      end else begin : g_pre_div
         logic [PRE_W-1:0] pre_cnt;
         logic             pre_last;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pre_cnt <= '0;
            else if (!run)     pre_cnt <= '0;
            else if (ref_tick) pre_cnt <= pre_last ? '0 : pre_cnt + 1'b1;
         end
         assign pre_last = (pre_cnt == PRE_W'(PRE_DIV - 1));
         assign step     = ref_tick && (!pre_sel || pre_last);
      end
   endgenerate
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] mod_q,
   input  logic             tm_wr,
   input  logic [CNT_W-1:0] wr_mod,
   input  logic             lvl_on,
   input  logic             lvl_kill,
   input  logic             ack_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             pend_q
);
   logic             running;
   logic             expire;
   logic [CNT_W-1:0] cnt_d;
   logic             pend_d;

   assign running = (mod_q != '0);
   assign expire  = running && step && (cnt_q <= CNT_W'(1));

   always_comb begin
      cnt_d  = cnt_q;
      pend_d = pend_q && !ack_clr && !lvl_kill;
      if (tm_wr && (wr_mod == '0)) begin
         cnt_d  = '0;
         pend_d = 1'b0;
      end else if (tm_wr && !running) begin
         cnt_d = wr_mod;
      end else if (running && step) begin
         if (expire) begin
            cnt_d = mod_q;
            if (lvl_on && !lvl_kill) pend_d = 1'b1;
         end else begin
            cnt_d = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/pit_arbiter.sv
module pit_arbiter
   import pit_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic             pend_q,
   input  lvl_t             lvl_q,
   input  logic [VEC_W-1:0] vec_q,
   input  lvl_t             ext_level,
   input  lvl_t             ipl_mask,
   input  logic             iack,
   input  lvl_t             iack_level,
   output lvl_t             req_level,
   output logic             req_is_timer,
   output logic             req_take,
   output logic             iack_hit,
   output logic [VEC_W-1:0] iack_vector
);
   lvl_t tmr_level;

   assign tmr_level    = pend_q ? lvl_q : '0;
   assign req_level    = lvl_max(tmr_level, ext_level);
   assign req_is_timer = (tmr_level != '0) && (tmr_level >= ext_level);
   assign req_take     = (req_level > ipl_mask);
   assign iack_hit     = iack && (tmr_level != '0) && (iack_level == tmr_level);
   assign iack_vector  = iack_hit ? vec_q : '0;
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
   import pit_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int VEC_W   = 8,
   parameter int DATA_W  = 16,
   parameter int REF_DIV = 4,
   parameter int PRE_DIV = 512,
   parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              lp_stop,
   input  logic [2:0]        ext_level,
   input  logic [2:0]        ipl_mask,
   output logic [2:0]        req_level,
   output logic              req_is_timer,
   output logic              req_take,
   input  logic              iack,
   input  logic [2:0]        iack_level,
   output logic              iack_hit,
   output logic [VEC_W-1:0]  iack_vector
);
   generate
      if (DATA_W < CNT_W + 1 || DATA_W < VEC_W + LVL_W) begin : g_bad_width
         $error("periodic_irq_timer: DATA_W too narrow for register fields");
      end
      if (REF_DIV < 1 || PRE_DIV < 1 || CNT_W < 2) begin : g_bad_div
         $error("periodic_irq_timer: divider or counter parameter out of range");
      end
   endgenerate

   logic [CNT_W-1:0] mod_q;
   logic             pre_q;
   lvl_t             lvl_q;
   logic [VEC_W-1:0] vec_q;
   logic             tm_wr;
   logic [CNT_W-1:0] wr_mod;
   logic             lvl_kill;
   logic             step;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;

   pit_regs #(
      .CNT_W(CNT_W), .VEC_W(VEC_W), .DATA_W(DATA_W), .VEC_RST(VEC_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_q(mod_q),
      .pre_q(pre_q), .lvl_q(lvl_q), .vec_q(vec_q), .tm_wr(tm_wr),
      .wr_mod(wr_mod), .lvl_kill(lvl_kill)
   );

   pit_tick_gen #(
      .REF_DIV(REF_DIV), .PRE_DIV(PRE_DIV)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .run(mod_q != '0), .pre_sel(pre_q), .step(step)
   );

   pit_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .mod_q(mod_q), .tm_wr(tm_wr),
      .wr_mod(wr_mod), .lvl_on(lvl_q != '0), .lvl_kill(lvl_kill),
      .ack_clr(iack_hit), .cnt_q(cnt_q), .pend_q(pend_q)
   );

   pit_arbiter #(
      .VEC_W(VEC_W)
   ) u_arb (
      .pend_q(pend_q), .lvl_q(lvl_q), .vec_q(vec_q), .ext_level(ext_level),
      .ipl_mask(ipl_mask), .iack(iack), .iack_level(iack_level),
      .req_level(req_level), .req_is_timer(req_is_timer), .req_take(req_take),
      .iack_hit(iack_hit), .iack_vector(iack_vector)
   );
endmodule

// File: rtl/periodic_irq_timer_chk.sv
module periodic_irq_timer_chk #(
   parameter int CNT_W = 8,
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_addr,
   input logic             lp_stop,
   input logic [2:0]       ext_level,
   input logic [2:0]       ipl_mask,
   input logic [2:0]       req_level,
   input logic             req_is_timer,
   input logic             req_take,
   input logic             iack,
   input logic [2:0]       iack_level,
   input logic             iack_hit,
   input logic [VEC_W-1:0] iack_vector,
   input logic [CNT_W-1:0] mod_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             pend_q,
   input logic [2:0]       lvl_q,
   input logic [VEC_W-1:0] vec_q,
   input logic             step
);
   logic timing_wr;
   assign timing_wr = reg_wr && !reg_addr;

   p_pend_from_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(step && (mod_q != '0) && (cnt_q <= CNT_W'(1))));

   p_lvl_zero_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q == 3'd0) |-> !req_is_timer);

   p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mod_q == '0) && !timing_wr) |=> ($stable(cnt_q) && !pend_q));

   p_lpstop_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_stop && (mod_q != '0) && !timing_wr && step && (cnt_q > CNT_W'(1)))
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

   p_tie_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && (lvl_q != 3'd0) && (lvl_q == ext_level)) |-> req_is_timer);

   p_max_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_level >= ext_level) && (!pend_q || (req_level >= lvl_q)));

   p_take_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_take |-> (req_level > ipl_mask));

   p_ack_vector_r12: assert property (@(posedge clk) disable iff (!rst_n)
      iack_hit |-> (iack_vector == vec_q));

   p_ack_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_hit && !(step && (cnt_q <= CNT_W'(1)))) |=> !pend_q);

   p_wrong_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && (!pend_q || (iack_level != lvl_q))) |-> (!iack_hit && (iack_vector == '0)));
endmodule

bind periodic_irq_timer periodic_irq_timer_chk #(
   .CNT_W(CNT_W), .VEC_W(VEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .lp_stop(lp_stop), .ext_level(ext_level), .ipl_mask(ipl_mask),
   .req_level(req_level), .req_is_timer(req_is_timer), .req_take(req_take),
   .iack(iack), .iack_level(iack_level), .iack_hit(iack_hit),
   .iack_vector(iack_vector), .mod_q(mod_q), .cnt_q(cnt_q), .pend_q(pend_q),
   .lvl_q(lvl_q), .vec_q(vec_q), .step(step)
);

// File: tb/periodic_irq_timer_tb.sv
`timescale 1ns/1ps
module periodic_irq_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        lp_stop = 1'b0;
   logic [2:0]  ext_level = '0;
   logic [2:0]  ipl_mask = '0;
   logic [2:0]  req_level;
   logic        req_is_timer;
   logic        req_take;
   logic        iack = 1'b0;
   logic [2:0]  iack_level = '0;
   logic        iack_hit;
   logic [7:0]  iack_vector;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit mon_en = 1'b1;
   bit auto_ack = 1'b1;
   bit ack_active = 1'b0;
   bit prev_req = 1'b0;
   logic [7:0] exp_vec = 8'h0F;
   int exp_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   periodic_irq_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lp_stop(lp_stop),
      .ext_level(ext_level), .ipl_mask(ipl_mask), .req_level(req_level),
      .req_is_timer(req_is_timer), .req_take(req_take), .iack(iack),
      .iack_level(iack_level), .iack_hit(iack_hit), .iack_vector(iack_vector)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Driver side: register write, returns the counter value of the write edge
   task automatic wr(input bit addr, input logic [15:0] data, output int c0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
      c0 = cyc;
   endtask

   task automatic expect_at(input int c);
      exp_q.push_back(c);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic wait_drain(input string req);
      int guard = 0;
      while (exp_q.size() != 0 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      chk(exp_q.size() == 0, req, "expected request never seen, pending items", exp_q.size(), 0);
   endtask

   task automatic rd_chk(input bit addr, input logic [15:0] exp, input string req);
      @(negedge clk);
      reg_addr = addr;
      #1;
      chk(reg_rdata == exp, req, "register read", reg_rdata, exp);
   endtask

   // Monitor: pops expected request cycles and optionally acknowledges
   always @(negedge clk) begin
      bit cur;
      if (ack_active) begin
         iack = 1'b0;
         ack_active = 1'b0;
      end
      cur = rst_n && (req_level != 3'd0) && req_is_timer;
      if (mon_en && cur && !prev_req) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected timer request at cycle", cyc, -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(cyc == e, "R2", "timer request cycle", cyc, e);
         end
         if (auto_ack) begin
            iack = 1'b1;
            iack_level = req_level;
            ack_active = 1'b1;
            #1;
            chk(iack_hit == 1'b1, "R12", "iack_hit on matching level", iack_hit, 1);
            chk(iack_vector == exp_vec, "R12", "iack_vector", iack_vector, exp_vec);
         end
      end
      prev_req = cur;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int c0;
      int c1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk(1'b0, 16'h0000, "R1");
      rd_chk(1'b1, 16'h000F, "R1");
      chk(req_level == 3'd0, "R1", "req_level after reset", req_level, 0);
      chk(req_take == 1'b0, "R1", "req_take after reset", req_take, 0);

      // R2, R4: level 3, vector 0x41, modulus 5, no prescale
      exp_vec = 8'h41;
      wr(1'b1, 16'h0341, c0);
      wr(1'b0, 16'h0005, c0);
      expect_at(c0 + 20);
      expect_at(c0 + 40);
      expect_at(c0 + 60);
      wait_drain("R4");
      // R6: hold the next one pending, then stop with modulus 0
      auto_ack = 1'b0;
      expect_at(c0 + 80);
      wait_drain("R4");
      chk(req_level == 3'd3, "R6", "request held before stop", req_level, 3);
      wr(1'b0, 16'h0000, c1);
      chk(req_level == 3'd0, "R6", "modulus 0 clears pending", req_level, 0);
      rd_chk(1'b0, 16'h0000, "R6");
      repeat (100) @(negedge clk);
      chk(req_level == 3'd0, "R6", "no request while stopped", req_level, 0);
      auto_ack = 1'b1;

      // R3, R7: prescale 512, modulus 2, low-power stop asserted
      lp_stop = 1'b1;
      wr(1'b0, 16'h0102, c0);
      expect_at(c0 + 4 * 512 * 2);
      wait_drain("R3");
      chk(1'b1, "R7", "period unchanged under lp_stop", 0, 0);
      wr(1'b0, 16'h0000, c0);
      lp_stop = 1'b0;

      // R8: modulus 4 running, change to 7 mid period
      wr(1'b0, 16'h0004, c0);
      expect_at(c0 + 16);
      expect_at(c0 + 16 + 28);
      wait_until(c0 + 6);
      wr(1'b0, 16'h0007, c1);
      wait_drain("R8");
      wr(1'b0, 16'h0000, c1);

      // R5: level 0, counter keeps phase
      wr(1'b1, 16'h0041, c1);
      wr(1'b0, 16'h0006, c0);
      wait_until(c0 + 55);
      chk(req_level == 3'd0, "R5", "no request at level 0", req_level, 0);
      exp_vec = 8'h5A;
      wr(1'b1, 16'h025A, c1);
      expect_at(c0 + 72);
      expect_at(c0 + 96);
      wait_drain("R5");
      auto_ack = 1'b0;
      expect_at(c0 + 120);
      wait_drain("R4");
      mon_en = 1'b0;

      // R9, R10, R11: request pending at level 2
      @(negedge clk);
      ext_level = 3'd2; ipl_mask = 3'd1;
      #1;
      chk(req_is_timer == 1'b1, "R9", "tie goes to timer", req_is_timer, 1);
      chk(req_level == 3'd2, "R10", "req_level at tie", req_level, 2);
      chk(req_take == 1'b1, "R11", "take with level 2 over mask 1", req_take, 1);
      @(negedge clk);
      ext_level = 3'd5; ipl_mask = 3'd5;
      #1;
      chk(req_level == 3'd5, "R10", "higher external wins level", req_level, 5);
      chk(req_is_timer == 1'b0, "R10", "external is source", req_is_timer, 0);
      chk(req_take == 1'b0, "R11", "no take when level equals mask", req_take, 0);
      @(negedge clk);
      ipl_mask = 3'd4;
      #1;
      chk(req_take == 1'b1, "R11", "take when level above mask", req_take, 1);
      @(negedge clk);
      ext_level = 3'd0; ipl_mask = 3'd0;

      // R13: wrong-level acknowledge
      iack = 1'b1; iack_level = 3'd1;
      #1;
      chk(iack_hit == 1'b0, "R13", "no hit on other level", iack_hit, 0);
      chk(iack_vector == 8'h00, "R13", "vector zero on other level", iack_vector, 0);
      @(negedge clk);
      iack = 1'b0;
      #1;
      chk(req_level == 3'd2, "R13", "request still pending", req_level, 2);
      // R12: correct acknowledge clears
      @(negedge clk);
      iack = 1'b1; iack_level = 3'd2;
      #1;
      chk(iack_hit == 1'b1, "R12", "hit on matching level", iack_hit, 1);
      chk(iack_vector == 8'h5A, "R12", "vector on matching level", iack_vector, 8'h5A);
      @(negedge clk);
      iack = 1'b0;
      #1;
      chk(req_level == 3'd0, "R12", "pending cleared after ack", req_level, 0);

      wr(1'b0, 16'h0000, c1);
      mon_en = 1'b1;
      auto_ack = 1'b1;
      repeat (50) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "scoreboard empty at end", exp_q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule